// File: doc/BRIEF.md
# SIMT Lane Execution Mask Unit

This block sits on the scalar side of a wide SIMD wavefront and owns the per-lane execution mask. Each mask bit enables one vector lane. The sequencer issues structured divergence operations to the block: branch entry, branch swap, reconvergence, loop-exit accumulation and loop back-edge. Each operation reads one entry of a small file of saved masks and may write one entry. A per-lane condition vector produced by vector compares enters on a port. The sequencer uses the outputs to decide on skip branches and loop branches.

Every accepted operation takes one clock, and its results are visible in the cycle after the edge that accepted it. The block can run with 64 lanes or, through a static mode input, with the low 32 lanes only.

The control state machine has two states. **ST_BOOT** is entered on reset. On the first clock after reset it loads the full mask for the selected lane count and moves to **ST_RUN** (transition *boot_done*). **ST_RUN** accepts operations (transition *issue*, which stays in ST_RUN) and leaves only through reset. The operation decoder treats codes as named states of the datapath: NOP, IF, ELSE, ENDIF, BREAK, LOOP.

Top module: `exm_unit`

## Requirements
- R1: After reset release, `ready` rises one cycle later. At that point `exec_mask` is all ones in 64-lane mode and 32'hFFFFFFFF in the low half (upper half zero) in 32-lane mode, every saved entry reads zero, and `mask_zero`, `take_back` and `scc` are 0. Operations are accepted only while `ready` is high.
- R2: IF (op_code 1, `simple_if`=0) sets exec to old AND cond and writes saved[dst] = new XOR old, which are the lanes switched off.
- R3: IF with `simple_if`=1 sets exec the same way and writes saved[dst] = old exec.
- R4: ELSE (op_code 2) writes saved[dst] = old exec and sets exec to saved[src] AND NOT old exec.
- R5: ENDIF (op_code 3) sets exec to exec OR saved[src].
- R6: BREAK (op_code 4) writes saved[dst] = (exec AND cond) OR saved[src]. With `brk_bypass`=1 it uses cond unmasked by exec. Exec is unchanged.
- R7: LOOP (op_code 5) sets exec to exec AND NOT saved[src]. `take_back` is high for exactly the following cycle when that result is non-zero.
- R8: `mask_zero` is high in the cycle after an IF or ELSE whose new exec is zero, and low after any other cycle.
- R9: `scc` takes the non-zero test of the mask written by the last accepted operation: the new exec for IF/ELSE/ENDIF/LOOP, and the new saved value for BREAK. It holds otherwise.
- R10: In 32-lane mode (`narrow`=1, changed only under reset), bits 63:32 of cond are ignored, and the upper halves of exec and of every written saved value stay zero.
- R11: Operands are read before the operation's writes. ELSE with dst equal to src uses the old saved[src].
- R12: With `op_valid` low, or with op_code 0, 6 or 7, neither exec nor the saved file changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow | input | 1 | 1 selects 32-lane mode; static outside reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 NOP, 1 IF, 2 ELSE, 3 ENDIF, 4 BREAK, 5 LOOP, 6/7 NOP |
| simple_if | input | 1 | IF stores the full old mask |
| brk_bypass | input | 1 | BREAK skips masking cond with exec |
| cond | input | 64 | Per-lane condition vector |
| dst_idx | input | 3 | Saved-file entry written |
| src_idx | input | 3 | Saved-file entry read |
| rd_idx | input | 3 | Saved-file entry shown on rd_mask |
| rd_mask | output | 64 | Contents of saved[rd_idx] |
| ready | output | 1 | Unit accepts operations |
| exec_mask | output | 64 | Current execution mask |
| mask_zero | output | 1 | No lane left after IF/ELSE |
| take_back | output | 1 | Loop back-edge should be taken |
| scc | output | 1 | Last written mask non-zero |

## Verification
The saved-file write and the operand read of the same entry can fall in the same cycle, both within one ELSE whose destination equals its source and across back-to-back operations where the next one reads what the previous one just wrote. The bench provokes the first case in a directed ELSE with equal indices and the second through long pseudo-random streams of unbroken operations with small index ranges in both lane modes. A bench-side model computes each result from the requirements, and after every operation the bench compares exec, the flags and all eight saved entries.

// File: rtl/exm_pkg.sv
package exm_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_IF    = 3'd1,
        OP_ELSE  = 3'd2,
        OP_ENDIF = 3'd3,
        OP_BREAK = 3'd4,
        OP_LOOP  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } exm_op_e;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } exm_state_e;

endpackage

// File: rtl/exm_savefile.sv
module exm_savefile #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDXW-1:0]  widx,
    input  logic [LANES-1:0] wdata,
    input  logic [IDXW-1:0]  ridx_a,
    output logic [LANES-1:0] rdata_a,
    input  logic [IDXW-1:0]  ridx_b,
    output logic [LANES-1:0] rdata_b
);

    logic [LANES-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/exm_alu.sv
module exm_alu
    import exm_pkg::*;
#(
    parameter int LANES = 64
) (
    input  exm_op_e          op,
    input  logic             simple_if,
    input  logic             brk_bypass,
    input  logic [LANES-1:0] lane_mask,
    input  logic [LANES-1:0] cur_exec,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] src_val,
    output logic [LANES-1:0] nxt_exec,
    output logic             exec_we,
    output logic             wr_en,
    output logic [LANES-1:0] wr_val,
    output logic             zero_nxt,
    output logic             back_nxt,
    output logic             scc_we,
    output logic             scc_val
);

    logic [LANES-1:0] cur;
    logic [LANES-1:0] cnd;
    logic [LANES-1:0] sv;
    logic [LANES-1:0] hit;

    assign cur = cur_exec & lane_mask;
    assign cnd = cond & lane_mask;
    assign sv  = src_val & lane_mask;

    always_comb begin
        nxt_exec = cur;
        exec_we  = 1'b0;
        wr_en    = 1'b0;
        wr_val   = '0;
        zero_nxt = 1'b0;
        back_nxt = 1'b0;
        scc_we   = 1'b0;
        scc_val  = 1'b0;
        hit      = '0;
        unique case (op)
            OP_IF: begin
                hit      = cur & cnd;
                nxt_exec = hit;
                exec_we  = 1'b1;
                wr_en    = 1'b1;
                wr_val   = simple_if ? cur : (hit ^ cur);
                zero_nxt = (hit == '0);
                scc_we   = 1'b1;
                scc_val  = (hit != '0);
            end
            OP_ELSE: begin
                hit      = (cur | sv) ^ cur;
                nxt_exec = hit;
                exec_we  = 1'b1;
                wr_en    = 1'b1;
                wr_val   = cur;
                zero_nxt = (hit == '0);
                scc_we   = 1'b1;
                scc_val  = (hit != '0);
            end
            OP_ENDIF: begin
                hit      = cur | sv;
                nxt_exec = hit;
                exec_we  = 1'b1;
                scc_we   = 1'b1;
                scc_val  = (hit != '0);
            end
            OP_BREAK: begin
                hit     = (brk_bypass ? cnd : (cur & cnd)) | sv;
                wr_en   = 1'b1;
                wr_val  = hit;
                scc_we  = 1'b1;
                scc_val = (hit != '0);
            end
            OP_LOOP: begin
                hit      = cur & ~sv;
                nxt_exec = hit;
                exec_we  = 1'b1;
                back_nxt = (hit != '0);
                scc_we   = 1'b1;
                scc_val  = (hit != '0);
            end
            default: begin
                hit = '0;
            end
        endcase
    end

endmodule

// File: rtl/exm_unit.sv
module exm_unit
    import exm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int HALF = LANES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic             simple_if,
    input  logic             brk_bypass,
    input  logic [LANES-1:0] cond,
    input  logic [IDXW-1:0]  dst_idx,
    input  logic [IDXW-1:0]  src_idx,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [LANES-1:0] rd_mask,
    output logic             ready,
    output logic [LANES-1:0] exec_mask,
    output logic             mask_zero,
    output logic             take_back,
    output logic             scc
);

    exm_state_e       state_q, state_d;
    exm_op_e          op;
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] src_val;
    logic [LANES-1:0] nxt_exec;
    logic [LANES-1:0] wr_val;
    logic             exec_we, wr_en, zero_nxt, back_nxt, scc_we, scc_val;
    logic             issue;

    assign lane_mask = {{(LANES-HALF){~narrow}}, {HALF{1'b1}}};
    assign op        = exm_op_e'(op_code);
    assign ready     = (state_q == ST_RUN);
    assign issue     = ready & op_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state: boot_done, then issue loops in ST_RUN
    always_comb begin
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    exm_savefile #(.LANES(LANES), .DEPTH(DEPTH)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (issue & wr_en),
        .widx    (dst_idx),
        .wdata   (wr_val),
        .ridx_a  (src_idx),
        .rdata_a (src_val),
        .ridx_b  (rd_idx),
        .rdata_b (rd_mask)
    );

    exm_alu #(.LANES(LANES)) u_alu (
        .op         (op),
        .simple_if  (simple_if),
        .brk_bypass (brk_bypass),
        .lane_mask  (lane_mask),
        .cur_exec   (exec_mask),
        .cond       (cond),
        .src_val    (src_val),
        .nxt_exec   (nxt_exec),
        .exec_we    (exec_we),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .zero_nxt   (zero_nxt),
        .back_nxt   (back_nxt),
        .scc_we     (scc_we),
        .scc_val    (scc_val)
    );

    // Output registers, driven per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_mask <= '0;
            mask_zero <= 1'b0;
            take_back <= 1'b0;
            scc       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    exec_mask <= lane_mask;
                    mask_zero <= 1'b0;
                    take_back <= 1'b0;
                end
                ST_RUN: begin
                    if (issue && exec_we) exec_mask <= nxt_exec;
                    mask_zero <= issue & zero_nxt;
                    take_back <= issue & back_nxt;
                    if (issue && scc_we) scc <= scc_val;
                end
                default: begin
                    exec_mask <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/exm_unit_chk.sv
module exm_unit_chk #(
    parameter int LANES = 64,
    localparam int HALF = LANES / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             narrow,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             ready,
    input logic [LANES-1:0] exec_mask,
    input logic             mask_zero,
    input logic             take_back
);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !op_valid) |=> $stable(exec_mask));

    a_r7_back_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        take_back |-> (exec_mask != '0));

    a_r8_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mask_zero |-> (exec_mask == '0));

    a_r8_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        mask_zero |-> $past(ready && op_valid && (op_code == 3'd1 || op_code == 3'd2)));

    a_r6_break_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_valid && op_code == 3'd4) |=> $stable(exec_mask));

    a_r5_endif_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && op_valid && op_code == 3'd3) |=>
            ((exec_mask & $past(exec_mask)) == $past(exec_mask)));

    a_r10_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && narrow && $stable(narrow)) |-> (exec_mask[LANES-1:HALF] == '0));

endmodule

bind exm_unit exm_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .narrow    (narrow),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .ready     (ready),
    .exec_mask (exec_mask),
    .mask_zero (mask_zero),
    .take_back (take_back)
);

// File: tb/exm_unit_bench.sv
`timescale 1ns/1ps
module exm_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        simple_if = 1'b0;
    logic        brk_bypass = 1'b0;
    logic [63:0] cond = '0;
    logic [2:0]  dst_idx = '0;
    logic [2:0]  src_idx = '0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_mask;
    logic        ready;
    logic [63:0] exec_mask;
    logic        mask_zero;
    logic        take_back;
    logic        scc;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_exec;
    logic [63:0] m_save [8];
    logic        m_zero, m_back, m_scc;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #2.5 clk = ~clk;

    exm_unit u_exm_unit (
        .clk(clk), .rst_n(rst_n), .narrow(narrow), .op_valid(op_valid),
        .op_code(op_code), .simple_if(simple_if), .brk_bypass(brk_bypass),
        .cond(cond), .dst_idx(dst_idx), .src_idx(src_idx), .rd_idx(rd_idx),
        .rd_mask(rd_mask), .ready(ready), .exec_mask(exec_mask),
        .mask_zero(mask_zero), .take_back(take_back), .scc(scc)
    );

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: run did not finish got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "exec", exec_mask, m_exec);
        chk("R8", "mask_zero", {63'd0, mask_zero}, {63'd0, m_zero});
        chk("R7", "take_back", {63'd0, take_back}, {63'd0, m_back});
        chk("R9", "scc", {63'd0, scc}, {63'd0, m_scc});
        for (int e = 0; e < 8; e++) begin
            rd_idx = e[2:0];
            #0.1;
            chk(tag, "saved", rd_mask, m_save[e]);
        end
    endtask

    task automatic do_reset(input logic nar);
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        narrow = nar;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready", {63'd0, ready}, 64'd1);
        m_exec = nar ? 64'h0000_0000_FFFF_FFFF : '1;
        for (int e = 0; e < 8; e++) m_save[e] = '0;
        m_zero = 1'b0; m_back = 1'b0; m_scc = 1'b0;
        check_all("R1");
    endtask

    // Model from the requirements; returns the tag of the exec check
    task automatic model(input logic v, input logic [2:0] oc, input logic si,
                         input logic bb, input logic [63:0] c,
                         input logic [2:0] d, input logic [2:0] s, output string tag);
        logic [63:0] lm, cur, cn, sv, n;
        lm  = narrow ? 64'h0000_0000_FFFF_FFFF : '1;
        cur = m_exec & lm;
        cn  = c & lm;
        sv  = m_save[s] & lm;
        m_zero = 1'b0;
        m_back = 1'b0;
        tag = "R12";
        if (v) begin
            case (oc)
                3'd1: begin
                    n = cur & cn;
                    m_save[d] = si ? cur : (n ^ cur);
                    m_exec = n; m_zero = (n == 0); m_scc = (n != 0);
                    tag = si ? "R3" : "R2";
                end
                3'd2: begin
                    n = sv & ~cur;
                    m_save[d] = cur;
                    m_exec = n; m_zero = (n == 0); m_scc = (n != 0);
                    tag = "R4";
                end
                3'd3: begin
                    n = cur | sv; m_exec = n; m_scc = (n != 0); tag = "R5";
                end
                3'd4: begin
                    n = (bb ? cn : (cur & cn)) | sv;
                    m_save[d] = n; m_scc = (n != 0); tag = "R6";
                end
                3'd5: begin
                    n = cur & ~sv; m_exec = n; m_back = (n != 0); m_scc = (n != 0);
                    tag = "R7";
                end
                default: tag = "R12";
            endcase
        end
        if (narrow) tag = {tag, "/R10"};
    endtask

    task automatic do_op(input logic v, input logic [2:0] oc, input logic si,
                         input logic bb, input logic [63:0] c,
                         input logic [2:0] d, input logic [2:0] s, input string extra);
        string tag;
        op_valid = v; op_code = oc; simple_if = si; brk_bypass = bb;
        cond = c; dst_idx = d; src_idx = s;
        model(v, oc, si, bb, c, d, s, tag);
        if (extra != "") tag = extra;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic sweep(input int n);
        logic [63:0] r, c;
        for (int k = 0; k < n; k++) begin
            r = next_rand();
            c = next_rand();
            case (r[9:8])
                2'd0: c = '0;
                2'd1: c = '1;
                default: ;
            endcase
            do_op(r[3:0] != 4'd0, r[6:4] == 3'd0 ? 3'd3 : r[6:4], r[12], r[13],
                  c, r[18:16] & 3'd3, r[22:20] & 3'd3, "");
        end
    endtask

    initial begin
        do_reset(1'b0);
        // R2: general IF, lanes switched off go to saved
        do_op(1, 3'd1, 0, 0, 64'h00FF_00FF_0F0F_F0F0, 3'd0, 3'd0, "R2");
        // R4: ELSE swaps to the skipped lanes
        do_op(1, 3'd2, 0, 0, '0, 3'd1, 3'd0, "R4");
        // R5: ENDIF restores
        do_op(1, 3'd3, 0, 0, '0, 3'd0, 3'd1, "R5");
        // R3: simple IF with empty condition, mask_zero expected
        do_op(1, 3'd1, 1, 0, '0, 3'd2, 3'd0, "R3");
        do_op(1, 3'd3, 0, 0, '0, 3'd0, 3'd2, "R5");
        // R11: ELSE with dst equal to src
        do_op(1, 3'd1, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 3'd5, 3'd0, "R2");
        do_op(1, 3'd2, 0, 0, '0, 3'd5, 3'd5, "R11");
        // R6: break accumulate, both variants
        do_op(1, 3'd4, 0, 0, 64'hF000_0000_0000_000F, 3'd6, 3'd7, "R6");
        do_op(1, 3'd4, 0, 1, 64'h0000_0001_0000_0000, 3'd6, 3'd6, "R6");
        // R7: loop removes break lanes
        do_op(1, 3'd5, 0, 0, '0, 3'd0, 3'd6, "R7");
        // R12: invalid and reserved codes
        do_op(0, 3'd1, 0, 0, '0, 3'd0, 3'd0, "R12");
        do_op(1, 3'd6, 0, 0, '1, 3'd1, 3'd1, "R12");
        do_op(1, 3'd7, 0, 0, '1, 3'd2, 3'd2, "R12");
        sweep(2000);
        do_reset(1'b1);
        // R10: upper condition bits ignored in narrow mode
        do_op(1, 3'd4, 0, 1, 64'hFFFF_FFFF_0000_0001, 3'd3, 3'd0, "R10");
        do_op(1, 3'd1, 0, 0, 64'hFFFF_FFFF_0000_0000, 3'd4, 3'd0, "R10");
        sweep(2000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule